// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Control

This block is the receive-side byte queue of a 16550-compatible serial port. A deserializer hands it one character per strobe, optionally flagged as a line break. Software drains the queue by reading the data register over a byte-wide register bus. It configures the queue through a control register whose writes can flush the receive queue, request a flush of the transmit side, switch FIFO mode on or off and pick a receive threshold.

The block keeps the receive indications that belong to the queue: data available, break seen and overrun. It offers them both as line-status bits on the bus and as direct outputs. A threshold flag tells the interrupt logic when the fill level has reached the programmed trigger point. The identification-register read returns the two FIFO-mode bits, with the low bits left to the interrupt logic. The stored control value is also brought out.

Top module: `uart_rx_fifo_ctrl`

## Requirements
- R1: Received bytes are returned in arrival order by reads of register address 0, and each read removes one byte. The queue holds at most 16 bytes.
- R2: A read of address 0 while the queue is empty returns 0x00 and changes no queue state.
- R3: Every arriving byte sets the data-ready flag, and a byte that arrives with the break strobe also sets the break flag. A data read that leaves the queue empty clears both flags, unless a byte arrives in the same cycle.
- R4: A byte that arrives while the queue holds 16 bytes is discarded and sets the overrun flag. A read of address 5 returns the line status, with data-ready in bit 0, overrun in bit 1 and break in bit 4 and all other bits 0. That read clears overrun and break, but a new overrun or break arriving in the same cycle takes priority.
- R5: A control write to address 2 stores the written value ANDed with 0xC9. Bits 1 and 2 are never stored.
- R6: A control write with bit 1 set empties the receive queue and clears data-ready and break. A write with bit 2 set raises tx_flush_o during the write cycle.
- R7: A control write whose bit 0 differs from the stored bit 0 performs both flush actions, whatever bits 1 and 2 hold.
- R8: A control write equal to the stored control value changes nothing and flushes nothing.
- R9: Stored bits 7:6 select the trigger level (00: 1, 01: 4, 10: 8, 11: 14). rx_thresh_o is high while the fill count is at or above that level.
- R10: A read of address 2 returns 0xC0 while stored bit 0 is 1, and 0x00 otherwise.
- R11: After reset the control value is 0x00, the queue is empty and all flags and outputs are 0.
- R12: When a receive flush and an arriving byte fall in the same cycle, the byte is discarded. When a flush and a data read coincide, no byte is removed beyond the flush. Overrun is not cleared by a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on this cycle) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Received character |
| rx_brk | input | 1 | Character carries a break condition |
| rx_ready_o | output | 1 | Data-ready flag |
| rx_break_o | output | 1 | Break flag |
| rx_overrun_o | output | 1 | Overrun flag |
| rx_thresh_o | output | 1 | Fill count at or above trigger level |
| tx_flush_o | output | 1 | Transmit-side flush request, write cycle only |
| fifo_ctrl_o | output | 8 | Stored control value |

## Verification
The main function is driven first with short bursts that are pushed and then read back, which shows ordering and the empty-read value. A run of seventeen arrivals follows; it separates correct dropping at the 16-byte boundary from wrap-around corruption. Control writes go through equal, toggling, reset-bit-only and trigger-only values, so that flush caused by the enable toggle can be told apart from flush caused by the reset bits. A long mixed phase overlaps arrivals, reads, status reads and control writes in the same cycle, which exposes priority mistakes between setting and clearing the flags.

// File: rtl/uart_rxf_pkg.sv
// Shared constants and helpers for the receive FIFO block.
// Assumes a byte-wide register bus with a 3-bit register address.
package uart_rxf_pkg;

    localparam logic [2:0] REG_DATA  = 3'd0;
    localparam logic [2:0] REG_CTRL  = 3'd2;
    localparam logic [2:0] REG_LSTAT = 3'd5;

    localparam logic [7:0] CTRL_KEEP = 8'hC9;
    localparam int         CB_EN     = 0;
    localparam int         CB_RXRST  = 1;
    localparam int         CB_TXRST  = 2;

    typedef struct packed {
        logic ready;
        logic ovr;
        logic brk;
    } rx_flags_t;

    // Maps the two trigger-select bits to a byte count.
    function automatic logic [4:0] trig_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_ctrl_reg.sv
// Control register: keeps the masked sticky bits and decodes the flush
// actions of each write. Assumes wr is already qualified by address.
module rxf_ctrl_reg
    import uart_rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] ctrl_q,
    output logic       rx_flush,
    output logic       tx_flush,
    output logic [4:0] trig_lvl
);

    logic changed;
    logic toggle;

    // Flush decode: an unchanged value is a no-op, an enable toggle forces both.
    always_comb begin
        changed  = wr && (wdata != ctrl_q);
        toggle   = wdata[CB_EN] ^ ctrl_q[CB_EN];
        rx_flush = changed && (wdata[CB_RXRST] || toggle);
        tx_flush = changed && (wdata[CB_TXRST] || toggle);
        trig_lvl = trig_of(ctrl_q[7:6]);
    end

    // Stored value: only the sticky bits survive a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (changed) ctrl_q <= wdata & CTRL_KEEP;
    end

endmodule

// File: rtl/rxf_store.sv
// Circular byte store with a fill counter. Arrivals into a full store
// are dropped and reported; flush has priority over push and pop.
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          drop,
    output logic          empty_next
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_d;
    logic          full, empty, do_push, do_pop;

    // Accept/remove decisions and next fill count.
    always_comb begin
        full       = (count == CW'(DEPTH));
        empty      = (count == '0);
        do_push    = push && !flush && !full;
        do_pop     = pop  && !flush && !empty;
        drop       = push && !flush && full;
        count_d    = flush ? '0 : count + CW'(do_push) - CW'(do_pop);
        empty_next = (count_d == '0);
        head       = empty ? '0 : mem[rd_ptr];
    end

    // One write port per entry, selected by the write pointer.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PW'(i))) mem[i] <= din;
        end
    end

    // Pointers and counter.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_d;
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/rxf_status.sv
// Receive status flags: data-ready, break and overrun.
// Sets win over clears raised in the same cycle.
module rxf_status
    import uart_rxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      push,
    input  logic      brk_in,
    input  logic      drop,
    input  logic      data_rd,
    input  logic      lstat_rd,
    input  logic      empty_next,
    output rx_flags_t flags
);

    logic arrive;
    assign arrive = push && !flush;

    // Flag update with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            if (flush)                        flags.ready <= 1'b0;
            else if (arrive)                  flags.ready <= 1'b1;
            else if (data_rd && empty_next)   flags.ready <= 1'b0;

            if (flush)                        flags.brk <= 1'b0;
            else if (arrive && brk_in)        flags.brk <= 1'b1;
            else if ((data_rd && empty_next) || lstat_rd) flags.brk <= 1'b0;

            if (drop)                         flags.ovr <= 1'b1;
            else if (lstat_rd)                flags.ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
// Receive FIFO with trigger control for a 16550-style serial port.
// Decodes the register bus, joins store, control and status, and drives
// the combinational read mux. Assumes one bus access per cycle.
module uart_rx_fifo_ctrl
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          rx_brk,
    output logic          rx_ready_o,
    output logic          rx_break_o,
    output logic          rx_overrun_o,
    output logic          rx_thresh_o,
    output logic          tx_flush_o,
    output logic [7:0]    fifo_ctrl_o
);

    logic          ctrl_wr, data_rd, lstat_rd;
    logic          rx_flush, drop, empty_next;
    logic [4:0]    trig_lvl;
    logic [7:0]    head;
    logic [CW-1:0] count;
    rx_flags_t     flags;

    // Register access decode.
    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == AW'(REG_CTRL));
        data_rd  = bus_rd && (bus_addr == AW'(REG_DATA));
        lstat_rd = bus_rd && (bus_addr == AW'(REG_LSTAT));
    end

    rxf_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (bus_wdata),
        .ctrl_q   (fifo_ctrl_o),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush_o),
        .trig_lvl (trig_lvl)
    );

    rxf_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .push       (rx_valid),
        .pop        (data_rd),
        .din        (rx_byte),
        .head       (head),
        .count      (count),
        .drop       (drop),
        .empty_next (empty_next)
    );

    rxf_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (rx_flush),
        .push       (rx_valid),
        .brk_in     (rx_brk),
        .drop       (drop),
        .data_rd    (data_rd),
        .lstat_rd   (lstat_rd),
        .empty_next (empty_next),
        .flags      (flags)
    );

    // Flag outputs and threshold compare.
    always_comb begin
        rx_ready_o   = flags.ready;
        rx_break_o   = flags.brk;
        rx_overrun_o = flags.ovr;
        rx_thresh_o  = int'(count) >= int'(trig_lvl);
    end

    // Read mux by register address.
    always_comb begin
        case (bus_addr)
            AW'(REG_DATA):  bus_rdata = head;
            AW'(REG_CTRL):  bus_rdata = {{2{fifo_ctrl_o[CB_EN]}}, 6'b0};
            AW'(REG_LSTAT): bus_rdata = {3'b0, flags.brk, 2'b0, flags.ovr, flags.ready};
            default:        bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rxf_checker.sv
// Property checker for uart_rx_fifo_ctrl, attached by bind below.
module rxf_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] count,
    input logic          rx_valid,
    input logic          rx_flush,
    input logic          tx_flush_o,
    input logic          rx_overrun_o,
    input logic          rx_ready_o,
    input logic          data_rd,
    input logic          ctrl_wr,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic [7:0]    fifo_ctrl_o
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH); // R1

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && count == '0) |-> bus_rdata == 8'h00); // R2

    AST_READY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> rx_ready_o); // R3

    AST_FULL_DROP_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_flush && int'(count) == DEPTH) |=> rx_overrun_o); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (count == '0) && !rx_ready_o); // R6

    AST_TOGGLE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (bus_wdata[0] != fifo_ctrl_o[0])) |-> (rx_flush && tx_flush_o)); // R7

    AST_SAME_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == fifo_ctrl_o) |-> (!rx_flush && !tx_flush_o)); // R8

    AST_SAME_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == fifo_ctrl_o) |=> $stable(fifo_ctrl_o)); // R8

endmodule

bind uart_rx_fifo_ctrl rxf_checker #(.DEPTH(DEPTH)) u_rxf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .count        (count),
    .rx_valid     (rx_valid),
    .rx_flush     (rx_flush),
    .tx_flush_o   (tx_flush_o),
    .rx_overrun_o (rx_overrun_o),
    .rx_ready_o   (rx_ready_o),
    .data_rd      (data_rd),
    .ctrl_wr      (ctrl_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .fifo_ctrl_o  (fifo_ctrl_o)
);

// File: tb/uart_rx_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared with the design every cycle,
// plus directed scenarios and a mixed traffic phase.
module uart_rx_fifo_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_ready_o, rx_break_o, rx_overrun_o, rx_thresh_o, tx_flush_o;
    logic [7:0] fifo_ctrl_o;

    always #5 clk = ~clk;

    uart_rx_fifo_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_brk(rx_brk),
        .rx_ready_o(rx_ready_o), .rx_break_o(rx_break_o),
        .rx_overrun_o(rx_overrun_o), .rx_thresh_o(rx_thresh_o),
        .tx_flush_o(tx_flush_o), .fifo_ctrl_o(fifo_ctrl_o)
    );

    int        n_tests = 0;
    int        n_fail  = 0;
    bit        done    = 1'b0;
    logic [7:0] q[$];
    logic [7:0] m_ctrl = 8'h00;
    bit        m_rdy = 0, m_brk = 0, m_ovr = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int trig_lvl(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : (s == 2'b10) ? 8 : 14;
    endfunction

    function automatic bit ctrl_changed();
        return bus_wr && bus_addr == 3'd2 && bus_wdata != m_ctrl;
    endfunction

    // Compare all outputs with the model state and current inputs.
    task automatic compare_all();
        int exp_rd;
        bit tg;
        tg = bus_wdata[0] != m_ctrl[0];
        case (bus_addr)
            3'd0:    exp_rd = (q.size() > 0) ? int'(q[0]) : 0;
            3'd2:    exp_rd = m_ctrl[0] ? 8'hC0 : 8'h00;
            3'd5:    exp_rd = {m_brk, 2'b00, m_ovr, m_rdy};
            default: exp_rd = 0;
        endcase
        chk("R1 R2 R4 R10 rdata", bus_rdata, exp_rd);
        chk("R3 ready", rx_ready_o, m_rdy);
        chk("R3 R4 break", rx_break_o, m_brk);
        chk("R4 overrun", rx_overrun_o, m_ovr);
        chk("R9 thresh", rx_thresh_o, q.size() >= trig_lvl(m_ctrl[7:6]));
        chk("R6 R7 tx_flush", tx_flush_o, ctrl_changed() && (bus_wdata[2] || tg));
        chk("R5 R8 ctrl", fifo_ctrl_o, m_ctrl);
    endtask

    // Advance the model by one clock using the held inputs.
    task automatic model_step();
        bit chg, fl, drd, lrd, drop;
        chg  = ctrl_changed();
        fl   = chg && (bus_wdata[1] || (bus_wdata[0] != m_ctrl[0]));
        drd  = bus_rd && bus_addr == 3'd0;
        lrd  = bus_rd && bus_addr == 3'd5;
        drop = !fl && rx_valid && q.size() == 16;
        if (chg) m_ctrl = bus_wdata & 8'hC9;
        if (fl) begin
            q.delete();
            m_rdy = 0;
            m_brk = 0;
        end else begin
            if (drd && q.size() > 0) void'(q.pop_front());
            if (rx_valid && !drop) q.push_back(rx_byte);
            if (drd && q.size() == 0) begin m_rdy = 0; m_brk = 0; end
            if (lrd) m_brk = 0;
            if (rx_valid) begin m_rdy = 1; if (rx_brk) m_brk = 1; end
        end
        if (drop) m_ovr = 1;
        else if (lrd) m_ovr = 0;
    endtask

    // One cycle: compare before the edge, step model at the edge, idle inputs.
    task automatic tick();
        #1 compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; rx_valid = 0; rx_brk = 0;
    endtask

    task automatic push(input logic [7:0] b, input bit brk = 0);
        rx_valid = 1; rx_byte = b; rx_brk = brk; tick();
    endtask

    task automatic rd(input logic [2:0] a);
        bus_rd = 1; bus_addr = a; tick();
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        bus_wr = 1; bus_addr = 3'd2; bus_wdata = d; tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R11: reset state
        chk("R11 ctrl", fifo_ctrl_o, 0);
        chk("R11 ready", rx_ready_o, 0);
        chk("R11 flags", {rx_break_o, rx_overrun_o, tx_flush_o}, 0);
        chk("R11 thresh", rx_thresh_o, 0);
        chk("R11 rdata", bus_rdata, 0);
        rst_n = 1;

        // R1: order of three bytes
        push(8'hA1); push(8'hB2); push(8'hC3);
        bus_addr = 0; #1 chk("R1 head", bus_rdata, 8'hA1);
        rd(0); rd(0); rd(0);
        // R2: empty read
        rd(0);
        // R3: break flag
        push(8'h11, 1); push(8'h22);
        rd(5); rd(0); rd(0);
        chk("R3 ready cleared", rx_ready_o, 0);
        // R4: fill past 16
        for (int i = 0; i < 17; i++) push(8'(i + 8'h40));
        chk("R4 overrun set", rx_overrun_o, 1);
        rd(5);
        chk("R4 overrun cleared", rx_overrun_o, 0);
        for (int i = 0; i < 16; i++) rd(0);
        // R5 R7 R10: enable with all bits, mask and flush
        push(8'h55);
        wr_ctrl(8'hFF);
        chk("R5 masked", fifo_ctrl_o, 8'hC9);
        chk("R7 flushed", rx_ready_o, 0);
        rd(2);
        // R8: equal write keeps data
        push(8'h66);
        wr_ctrl(8'hC9);
        chk("R8 no flush", rx_ready_o, 1);
        // R6: receive reset bit alone
        wr_ctrl(8'hCB);
        chk("R6 flush", rx_ready_o, 0);
        wr_ctrl(8'hCD);
        // R9: trigger levels
        wr_ctrl(8'h41);
        for (int i = 0; i < 4; i++) push(8'(i));
        chk("R9 level4", rx_thresh_o, 1);
        wr_ctrl(8'h81);
        chk("R9 level8", rx_thresh_o, 0);
        for (int i = 0; i < 4; i++) push(8'(i + 8'h10));
        wr_ctrl(8'hC1);
        chk("R9 level14", rx_thresh_o, 0);
        // R7 R10: disable toggles flush
        wr_ctrl(8'h00);
        rd(2);
        // R12: flush with simultaneous arrival and overrun kept
        for (int i = 0; i < 17; i++) push(8'(i));
        rx_valid = 1; rx_byte = 8'h99; bus_wr = 1; bus_addr = 2; bus_wdata = 8'h02; tick();
        chk("R12 byte dropped", rx_ready_o, 0);
        chk("R12 overrun kept", rx_overrun_o, 1);
        // simultaneous push and pop
        push(8'h31);
        rx_valid = 1; rx_byte = 8'h32; bus_rd = 1; bus_addr = 0; tick();
        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom % 10;
            if (op < 4) begin
                rx_valid = 1; rx_byte = 8'($urandom); rx_brk = ($urandom % 8) == 0;
            end
            if (op == 3 || op == 4 || op == 5) begin bus_rd = 1; bus_addr = 0; end
            else if (op == 6) begin bus_rd = 1; bus_addr = 5; end
            else if (op == 7) begin bus_rd = 1; bus_addr = 3'($urandom); end
            else if (op == 8 && ($urandom % 4) == 0) begin
                bus_wr = 1; bus_addr = 2;
                case ($urandom % 5)
                    0: bus_wdata = 8'h01;
                    1: bus_wdata = 8'h41;
                    2: bus_wdata = 8'h81;
                    3: bus_wdata = fifo_ctrl_o;
                    default: bus_wdata = 8'($urandom);
                endcase
            end
            tick();
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule